// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block decides, for each host access below the 1 MB line, where the access should go. It can go to system DRAM, to the primary I/O bus, or to the graphics port. The space from 0xC0000 to 0xFFFFF is covered by seven attribute bytes. Each byte holds 2-bit routing codes. The codes grant read and write permission to DRAM separately for every segment. The 128 KB video window is handled differently. Two enable inputs steer it between the primary bus and the graphics port, and a monochrome text range can be carved out of it.

Software loads the attribute bytes through a simple write port: a byte index and a data byte. A write takes effect on the next clock edge. The route output is combinational in the access address, the read/write flag, the two video enables and the stored codes. Bus protocol handling stays with the surrounding logic.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset every attribute code is 00, so reads and writes anywhere in 0xC0000-0xFFFFF route to the primary bus. The route encoding is 2'b00 DRAM, 2'b01 primary bus, 2'b10 graphics port, and 2'b11 never appears.
- R2: Addresses below 0xA0000 always route to DRAM, whatever the codes and video enables are.
- R3: A code decides the route per access direction. Code bit 0 set sends reads to DRAM, otherwise reads go to the primary bus. Code bit 1 set sends writes to DRAM, otherwise writes go to the primary bus. So 00 gives all to the bus, 01 gives reads to DRAM, 10 gives writes to DRAM, and 11 gives all to DRAM. Attribute segments never route to the graphics port.
- R4: Attribute index k (1 to 6) controls two 16 KB segments. Bits [1:0] control the segment at 0xC0000 + (k-1)*0x8000. Bits [5:4] control the 16 KB segment directly above it.
- R5: Bits [5:4] of attribute index 0 control the whole of 0xF0000-0xFFFFF. The other bits of every byte ([3:0] of index 0, [3:2] and [7:6] of indices 1-6) have no effect.
- R6: A write with `cfg_we` high changes the route from the next rising clock edge on, not before. A write to index 7 changes nothing.
- R7: With `vga_en` low, every access in 0xA0000-0xBFFFF routes to the primary bus.
- R8: With `vga_en` high and `mda_present` low, the whole video window routes to the graphics port.
- R9: With both `vga_en` and `mda_present` high, 0xB0000-0xB7FFF routes to the primary bus and the rest of the video window routes to the graphics port.
- R10: When `ADDR_W` exceeds 20, any address at or above 0x100000 routes to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the attribute register bank |
| rst_n | input | 1 | Active-low asynchronous reset; clears all codes |
| cfg_we | input | 1 | Attribute byte write strobe |
| cfg_sel | input | 3 | Attribute byte index (0-6 valid, 7 ignored) |
| cfg_wdata | input | 8 | Attribute byte value |
| vga_en | input | 1 | Video window enable towards the graphics port |
| mda_present | input | 1 | Monochrome text range stays on the primary bus |
| acc_addr | input | ADDR_W | Host access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| route | output | 2 | Destination of the current access |

## Verification
The bench builds the block with the default `ADDR_W` of 24. This leaves four address bits above the 1 MB line, so the out-of-window DRAM rule can be driven at both 0x100000 and 0xFFFFFF. The fixed 20-bit window layout means every one of the twelve 16 KB segments, the top 64 KB region and the monochrome carve-out can each be reached by directed addresses. Those addresses include the first and last byte of a segment, to catch off-by-one segment selection.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

   typedef enum logic [1:0] {
      RT_DRAM    = 2'b00,
      RT_PRIMARY = 2'b01,
      RT_GFX     = 2'b10
   } route_e;

   localparam int WIN_W      = 20;              // legacy window address bits
   localparam int CODE_W     = 2;
   localparam int ATTR_BYTES = 7;               // index 0 = top 64 KB, 1..6 = pairs
   localparam int SEL_W      = 3;
   localparam int SEG_LOG2   = 14;              // 16 KB granules
   localparam int BLK_W      = WIN_W - SEG_LOG2;
   localparam int NUM_SEG    = 2 * (ATTR_BYTES - 1);
   localparam int SEG_IDX_W  = $clog2(NUM_SEG);

   localparam logic [BLK_W-1:0] BLK_VIDEO_FIRST = 6'h28;   // 0xA0000
   localparam logic [BLK_W-1:0] BLK_SEG_FIRST   = 6'h30;   // 0xC0000
   localparam logic [BLK_W-1:0] BLK_TOP_FIRST   = BLK_SEG_FIRST + BLK_W'(NUM_SEG);
   localparam logic [4:0]       MDA_TAG         = 5'h16;   // 0xB0000 >> 15

endpackage

// File: rtl/lmr_attr_bank.sv
module lmr_attr_bank
   import lmr_pkg::*;
#(
   parameter int NUM_BYTES = ATTR_BYTES,
   parameter int SW        = SEL_W
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    wr_en,
   input  logic [SW-1:0]                           wr_sel,
   input  logic [7:0]                              wr_data,
   output logic [CODE_W-1:0]                       top_code,
   output logic [2*(NUM_BYTES-1)-1:0][CODE_W-1:0]  seg_code
);

   localparam int LO_BIT = 0;
   localparam int HI_BIT = 4;

   if (NUM_BYTES < 2) begin : g_bad_bytes
      $error("lmr_attr_bank: NUM_BYTES must be at least 2");
   end
   if ((1 << SW) < NUM_BYTES) begin : g_bad_sel
      $error("lmr_attr_bank: selector too narrow for NUM_BYTES");
   end

   // index 0 keeps only its upper field; the lower nibble is not stored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_code <= '0;
      end else if (wr_en && wr_sel == '0) begin
         top_code <= wr_data[HI_BIT +: CODE_W];
      end
   end

   for (genvar b = 1; b < NUM_BYTES; b++) begin : g_byte
      logic [CODE_W-1:0] lo_q;
      logic [CODE_W-1:0] hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_en && wr_sel == SW'(b)) begin
            lo_q <= wr_data[LO_BIT +: CODE_W];
            hi_q <= wr_data[HI_BIT +: CODE_W];
         end
      end

      assign seg_code[2*(b-1)]     = lo_q;
      assign seg_code[2*(b-1) + 1] = hi_q;
   end

endmodule

// File: rtl/lmr_seg_route.sv
module lmr_seg_route
   import lmr_pkg::*;
(
   input  logic [WIN_W-1:0]                 addr,
   input  logic                             is_write,
   input  logic [CODE_W-1:0]                top_code,
   input  logic [NUM_SEG-1:0][CODE_W-1:0]   seg_code,
   output logic                             hit,
   output route_e                           route
);

   logic [BLK_W-1:0]     blk;
   logic [BLK_W-1:0]     rel;
   logic [SEG_IDX_W-1:0] idx;
   logic [CODE_W-1:0]    code;
   logic                 to_dram;

   assign blk = addr[WIN_W-1:SEG_LOG2];
   assign rel = blk - BLK_SEG_FIRST;
   assign idx = rel[SEG_IDX_W-1:0];

   always_comb begin
      hit  = 1'b0;
      code = '0;
      if (blk >= BLK_TOP_FIRST) begin
         hit  = 1'b1;
         code = top_code;
      end else if (blk >= BLK_SEG_FIRST) begin
         hit  = 1'b1;
         code = seg_code[idx];
      end
   end

   // bit 0 grants reads to DRAM, bit 1 grants writes
   assign to_dram = is_write ? code[1] : code[0];
   assign route   = to_dram ? RT_DRAM : RT_PRIMARY;

endmodule

// File: rtl/lmr_video_route.sv
module lmr_video_route
   import lmr_pkg::*;
(
   input  logic [WIN_W-1:0] addr,
   input  logic             vga_en,
   input  logic             mda_present,
   output logic             hit,
   output route_e           route
);

   logic [BLK_W-1:0] blk;
   logic             in_mda;

   assign blk    = addr[WIN_W-1:SEG_LOG2];
   assign hit    = (blk >= BLK_VIDEO_FIRST) && (blk < BLK_SEG_FIRST);
   assign in_mda = (addr[WIN_W-1:15] == MDA_TAG);

   always_comb begin
      if (!vga_en) begin
         route = RT_PRIMARY;
      end else if (mda_present && in_mda) begin
         route = RT_PRIMARY;
      end else begin
         route = RT_GFX;
      end
   end

endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
   import lmr_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic              vga_en,
   input  logic              mda_present,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic [1:0]        route
);

   if (ADDR_W < WIN_W) begin : g_bad_addr
      $error("legacy_mem_router: ADDR_W must cover the 1 MB window");
   end

   logic [CODE_W-1:0]               top_code;
   logic [NUM_SEG-1:0][CODE_W-1:0]  seg_code;
   logic [WIN_W-1:0]                win_addr;
   logic                            above_win;
   logic                            seg_hit;
   logic                            vid_hit;
   route_e                          seg_rt;
   route_e                          vid_rt;
   route_e                          final_rt;

   assign win_addr = acc_addr[WIN_W-1:0];

   if (ADDR_W > WIN_W) begin : g_high
      assign above_win = |acc_addr[ADDR_W-1:WIN_W];
   end else begin : g_exact
      assign above_win = 1'b0;
   end

   lmr_attr_bank #(
      .NUM_BYTES (ATTR_BYTES),
      .SW        (SEL_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .top_code (top_code),
      .seg_code (seg_code)
   );

   lmr_seg_route u_seg (
      .addr     (win_addr),
      .is_write (acc_write),
      .top_code (top_code),
      .seg_code (seg_code),
      .hit      (seg_hit),
      .route    (seg_rt)
   );

   lmr_video_route u_vid (
      .addr        (win_addr),
      .vga_en      (vga_en),
      .mda_present (mda_present),
      .hit         (vid_hit),
      .route       (vid_rt)
   );

   always_comb begin
      if (above_win) begin
         final_rt = RT_DRAM;
      end else if (vid_hit) begin
         final_rt = vid_rt;
      end else if (seg_hit) begin
         final_rt = seg_rt;
      end else begin
         final_rt = RT_DRAM;
      end
   end

   assign route = final_rt;

endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vga_en,
   input logic              mda_present,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        route
);

   logic        hi_any;
   logic [19:0] a20;
   logic        in_low, in_video, in_attr, in_mono;

   if (ADDR_W > 20) begin : g_hi
      assign hi_any = |acc_addr[ADDR_W-1:20];
   end else begin : g_nohi
      assign hi_any = 1'b0;
   end

   assign a20      = acc_addr[19:0];
   assign in_low   = !hi_any && (a20 < 20'hA0000);
   assign in_video = !hi_any && (a20 >= 20'hA0000) && (a20 < 20'hC0000);
   assign in_attr  = !hi_any && (a20 >= 20'hC0000);
   assign in_mono  = in_video && (a20 >= 20'hB0000) && (a20 < 20'hB8000);

   AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
      in_low |-> route == 2'b00);                                   // R2
   AST_HIGH_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
      hi_any |-> route == 2'b00);                                   // R10
   AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      route != 2'b11);                                              // R1
   AST_ATTR_NO_GFX: assert property (@(posedge clk) disable iff (!rst_n)
      in_attr |-> route != 2'b10);                                  // R3
   AST_VGA_OFF_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_video && !vga_en) |-> route == 2'b01);                    // R7
   AST_VGA_ON_GFX: assert property (@(posedge clk) disable iff (!rst_n)
      (in_video && vga_en && !mda_present) |-> route == 2'b10);     // R8
   AST_MONO_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mono && vga_en && mda_present) |-> route == 2'b01);       // R9

endmodule

bind legacy_mem_router lmr_checker #(.ADDR_W(ADDR_W)) u_lmr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .vga_en      (vga_en),
   .mda_present (mda_present),
   .acc_addr    (acc_addr),
   .route       (route)
);

// File: tb/test_legacy_mem_router.sv
module test_legacy_mem_router;

   localparam int AW = 24;
   localparam logic [1:0] E_DRAM = 2'b00;
   localparam logic [1:0] E_PRI  = 2'b01;
   localparam logic [1:0] E_GFX  = 2'b10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [7:0]    cfg_wdata = '0;
   logic          vga_en = 1'b0;
   logic          mda_present = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_write = 1'b0;
   logic [1:0]    route;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   legacy_mem_router #(.ADDR_W(AW)) i_legacy_mem_router (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_wdata   (cfg_wdata),
      .vga_en      (vga_en),
      .mda_present (mda_present),
      .acc_addr    (acc_addr),
      .acc_write   (acc_write),
      .route       (route)
   );

   task automatic chk(input logic [AW-1:0] a, input logic wr,
                      input logic [1:0] exp, input string req);
      acc_addr  = a;
      acc_write = wr;
      #1;
      checks++;
      if (route !== exp) begin
         errors++;
         $display("FAIL %s addr=%h wr=%0d actual=%b expected=%b",
                  req, a, wr, route, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [7:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic t_reset;
      chk(24'h0C0000, 1'b0, E_PRI, "R1");
      chk(24'h0DC000, 1'b1, E_PRI, "R1");
      chk(24'h0FFFFF, 1'b1, E_PRI, "R1");
      chk(24'h000000, 1'b0, E_DRAM, "R2");
      chk(24'h09FFFF, 1'b1, E_DRAM, "R2");
   endtask

   task automatic t_codes;
      cfg_write(3'd1, 8'h01);
      chk(24'h0C0000, 1'b0, E_DRAM, "R3");
      chk(24'h0C0000, 1'b1, E_PRI,  "R3");
      cfg_write(3'd1, 8'h02);
      chk(24'h0C0000, 1'b0, E_PRI,  "R3");
      chk(24'h0C0000, 1'b1, E_DRAM, "R3");
      cfg_write(3'd1, 8'h03);
      chk(24'h0C3FFF, 1'b0, E_DRAM, "R3");
      chk(24'h0C3FFF, 1'b1, E_DRAM, "R3");
      cfg_write(3'd1, 8'h00);
      chk(24'h0C0000, 1'b1, E_PRI,  "R3");
   endtask

   task automatic t_segments;
      for (int k = 1; k <= 6; k++) begin
         logic [AW-1:0] base;
         base = AW'(32'h0C0000 + (k - 1) * 32'h8000);
         cfg_write(3'(k), 8'h30);
         chk(base,              1'b0, E_PRI,  "R4");
         chk(base + 24'h3FFF,   1'b1, E_PRI,  "R4");
         chk(base + 24'h4000,   1'b0, E_DRAM, "R4");
         chk(base + 24'h7FFF,   1'b1, E_DRAM, "R4");
         cfg_write(3'(k), 8'h00);
         chk(base + 24'h4000,   1'b0, E_PRI,  "R4");
      end
   endtask

   task automatic t_top_and_reserved;
      cfg_write(3'd0, 8'h0F);
      chk(24'h0F0000, 1'b0, E_PRI, "R5");
      chk(24'h0FFFFF, 1'b1, E_PRI, "R5");
      cfg_write(3'd0, 8'h30);
      chk(24'h0F0000, 1'b0, E_DRAM, "R5");
      chk(24'h0FFFFF, 1'b1, E_DRAM, "R5");
      chk(24'h0EFFFF, 1'b0, E_PRI,  "R5");
      cfg_write(3'd0, 8'h00);
      cfg_write(3'd1, 8'hCC);
      chk(24'h0C0000, 1'b0, E_PRI, "R5");
      chk(24'h0C4000, 1'b1, E_PRI, "R5");
      cfg_write(3'd1, 8'h00);
   endtask

   task automatic t_write_timing;
      cfg_write(3'd7, 8'hFF);
      chk(24'h0C0000, 1'b0, E_PRI, "R6");
      chk(24'h0F0000, 1'b1, E_PRI, "R6");
      chk(24'h0EC000, 1'b1, E_PRI, "R6");
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = 3'd1;
      cfg_wdata = 8'h03;
      chk(24'h0C0000, 1'b0, E_PRI, "R6");
      @(posedge clk);
      #2;
      chk(24'h0C0000, 1'b0, E_DRAM, "R6");
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_write(3'd1, 8'h00);
   endtask

   task automatic t_video;
      vga_en = 1'b0; mda_present = 1'b1;
      chk(24'h0A0000, 1'b0, E_PRI, "R7");
      chk(24'h0BFFFF, 1'b1, E_PRI, "R7");
      vga_en = 1'b1; mda_present = 1'b0;
      chk(24'h0A0000, 1'b0, E_GFX, "R8");
      chk(24'h0B4000, 1'b1, E_GFX, "R8");
      chk(24'h0BFFFF, 1'b0, E_GFX, "R8");
      mda_present = 1'b1;
      chk(24'h0B0000, 1'b0, E_PRI, "R9");
      chk(24'h0B7FFF, 1'b1, E_PRI, "R9");
      chk(24'h0AFFFF, 1'b0, E_GFX, "R9");
      chk(24'h0B8000, 1'b0, E_GFX, "R9");
      chk(24'h09FFFF, 1'b0, E_DRAM, "R2");
      vga_en = 1'b0; mda_present = 1'b0;
   endtask

   task automatic t_high;
      chk(24'h100000, 1'b0, E_DRAM, "R10");
      chk(24'h1C0000, 1'b1, E_DRAM, "R10");
      chk(24'hFFFFFF, 1'b0, E_DRAM, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_codes();
      t_segments();
      t_top_and_reserved();
      t_write_timing();
      t_video();
      t_high();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule